// File: doc/BRIEF.md
# Charger Backup-Mode Sequencer

This block is the digital controller that keeps a charger's input bus alive from the battery when the adapter goes away. The host arms it while the bus is valid. Once the block is armed in forward (charging) mode, it watches the digitized bus voltage against a fraction of the input-voltage-limit setpoint. When the bus sags below that fraction, the block takes over. It forces reverse operation on, disconnects the input switch, reports a backup status code and raises an interrupt. An input over-voltage event takes the same path whether or not the block is armed.

The host leaves backup by clearing the reverse-enable bit. The path out depends on the keep-switch configuration bit. If it is set, the block returns to forward mode in the next cycle and skips adapter qualification, so the power stage never stops. If it is clear, the block runs the full qualification delay before forward mode resumes. The same full delay applies on every ordinary adapter attach. If no input switch was found at power-on, arming is blocked.

Top module: `bkup_seq`

## Requirements
- R1: A write to the arm bit takes effect only while the bus is valid (vbus >= VALID, default 300) and a switch was found. Whenever the bus is below VALID, the arm bit reads 0 one cycle later.
- R2: A host write that sets reverse enable is ignored while the bus is valid. While the bus is invalid the write is accepted. A write of 0 is always accepted.
- R3: In forward mode with arm set, backup starts when vbus*10 < vlim*P. P is 4, 6, 7 or 8 for thr_sel codes 0, 1, 2 and 3. A bus voltage exactly at the threshold does not trigger.
- R4: One cycle after a trigger, stat is 4'b1100, rev_en is 1 and acdrv_off is 1.
- R5: On entry to backup with mask 0, irq is high for exactly one cycle and flag is set. With mask 1, neither irq nor flag changes.
- R6: ovp_trip in forward mode enters backup one cycle later with acdrv_off 1, even when the block is not armed.
- R7: With sw_found 0, the arm bit stays 0 whatever the host writes, and an undervoltage does not start backup.
- R8: In backup, a write of reverse enable 0 with keep_sw 1 gives forward mode (stat 4'b0001) one cycle later, with acdrv_off and rev_en cleared.
- R9: In backup, a write of reverse enable 0 with keep_sw 0 runs qualification. Qualification also runs when the bus becomes valid from idle. Forward mode appears 17 clock edges after the stimulus edge, and stat stays 4'b0000 until then.
- R10: stat reads 4'b0000 in idle and during qualification, and 4'b0001 in forward mode. A bus drop in forward mode with no trigger returns to idle.
- R11: A flag_clr pulse clears flag. If a backup entry and flag_clr occur in the same cycle, flag is set.
- R12: After reset, all outputs are 0 and stat is 4'b0000.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| we | input | 1 | Host write strobe for the three control bits |
| wd_arm | input | 1 | Write data: arm bit |
| wd_rev | input | 1 | Write data: reverse (bus-regulation) enable |
| wd_acdis | input | 1 | Write data: input-switch drive disable |
| mask | input | 1 | Interrupt/flag mask for backup entry |
| keep_sw | input | 1 | Fast return to forward mode on backup exit |
| thr_sel | input | 2 | Undervoltage threshold code |
| flag_clr | input | 1 | Host read-clear strobe for flag |
| vbus | input | W | Digitized bus voltage |
| vlim | input | W | Input-voltage-limit setpoint |
| ovp_trip | input | 1 | Input over-voltage comparator output |
| sw_found | input | 1 | Input switch detected at power-on |
| arm | output | 1 | Arm bit |
| rev_en | output | 1 | Reverse enable bit |
| acdrv_off | output | 1 | Input-switch drive disable |
| stat | output | 4 | Bus status code |
| irq | output | 1 | Single-cycle interrupt pulse |
| flag | output | 1 | Sticky bus flag |

## Verification
Every control output is a register. A trigger, a bus drop, a host write or a fast exit is therefore visible one clock edge after the stimulus is applied, and the bench checks these on the falling edge that follows that rising edge. The qualification path has a different latency: forward status appears 17 edges after the stimulus. The bench counts edges until stat changes and compares that count exactly, so both a short count and a long count are reported. The interrupt is checked on the entry edge and again on the edge after it, to confirm that it lasts one cycle.

// File: rtl/bkup_seq.sv
module bkup_seq #(
  parameter int W     = 12,
  parameter int VALID = 300,
  parameter int QLEN  = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         we,
  input  logic         wd_arm,
  input  logic         wd_rev,
  input  logic         wd_acdis,
  input  logic         mask,
  input  logic         keep_sw,
  input  logic [1:0]   thr_sel,
  input  logic         flag_clr,
  input  logic [W-1:0] vbus,
  input  logic [W-1:0] vlim,
  input  logic         ovp_trip,
  input  logic         sw_found,
  output logic         arm,
  output logic         rev_en,
  output logic         acdrv_off,
  output logic [3:0]   stat,
  output logic         irq,
  output logic         flag
);
  localparam int PW = W + 4;
  localparam int CW = (QLEN > 1) ? $clog2(QLEN) : 1;
  localparam logic [CW-1:0] QLAST = CW'(QLEN - 1);

  typedef enum logic [1:0] {S_IDLE, S_QUAL, S_FWD, S_BKUP} st_t;
  st_t st;
  logic [CW-1:0] cnt;
  logic [3:0] pct;
  logic bus_hi, below, enter, leave;

  assign bus_hi = (32'(vbus) >= VALID);

  always_comb begin
    case (thr_sel)
      2'd0:    pct = 4'd4;
      2'd1:    pct = 4'd6;
      2'd2:    pct = 4'd7;
      default: pct = 4'd8;
    endcase
  end

  assign below = (PW'(vbus) * PW'(10)) < (PW'(vlim) * PW'(pct));
  assign enter = (st == S_FWD) && ((arm && below) || ovp_trip);
  assign leave = (st == S_BKUP) && we && !wd_rev;

  always_comb begin
    case (st)
      S_FWD:   stat = 4'b0001;
      S_BKUP:  stat = 4'b1100;
      default: stat = 4'b0000;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st  <= S_IDLE;
      cnt <= '0;
    end else begin
      case (st)
        S_IDLE: if (bus_hi) begin st <= S_QUAL; cnt <= '0; end
        S_QUAL:
          if (!bus_hi) st <= S_IDLE;
          else if (cnt == QLAST) st <= S_FWD;
          else cnt <= cnt + 1'b1;
        S_FWD:
          if (enter) st <= S_BKUP;
          else if (!bus_hi) st <= S_IDLE;
        default:
          if (leave) begin
            if (keep_sw) st <= S_FWD;
            else begin st <= S_QUAL; cnt <= '0; end
          end
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      arm       <= 1'b0;
      rev_en    <= 1'b0;
      acdrv_off <= 1'b0;
      irq       <= 1'b0;
      flag      <= 1'b0;
    end else begin
      if (!sw_found || !bus_hi) arm <= 1'b0;
      else if (we)              arm <= wd_arm;

      if (enter)                  rev_en <= 1'b1;
      else if (we && !wd_rev)     rev_en <= 1'b0;
      else if (we && !bus_hi)     rev_en <= 1'b1;

      if (enter)                      acdrv_off <= 1'b1;
      else if (leave)                 acdrv_off <= 1'b0;
      else if (we && st != S_BKUP)    acdrv_off <= wd_acdis;

      irq <= enter && !mask;

      if (enter && !mask) flag <= 1'b1;
      else if (flag_clr)  flag <= 1'b0;
    end
  end

  a_r1_arm_low_bus: assert property (@(posedge clk) disable iff (!rst_n)
    !bus_hi |=> !arm);
  a_r2_rev_set_guard: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rev_en) |-> ($past(st) == S_FWD) || !$past(bus_hi));
  a_r4_entry_outputs: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> (stat == 4'b1100) && rev_en && acdrv_off);
  a_r5_irq_single: assert property (@(posedge clk) disable iff (!rst_n)
    irq |=> !irq);
  a_r5_irq_flag: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> flag);
  a_r7_no_switch: assert property (@(posedge clk) disable iff (!rst_n)
    !sw_found |=> !arm);
  a_r8_fast_exit: assert property (@(posedge clk) disable iff (!rst_n)
    (leave && keep_sw) |=> (stat == 4'b0001) && !acdrv_off);
endmodule

// File: tb/bkup_seq_test.sv
module bkup_seq_test;
  localparam int TCLK = 10;
  localparam int W = 12;

  logic clk = 1'b0, rst_n = 1'b0;
  logic we = 0, wd_arm = 0, wd_rev = 0, wd_acdis = 0;
  logic mask = 0, keep_sw = 0, flag_clr = 0, ovp_trip = 0, sw_found = 1;
  logic [1:0] thr_sel = 0;
  logic [W-1:0] vbus = 0, vlim = 12'd1000;
  logic arm, rev_en, acdrv_off, irq, flag;
  logic [3:0] stat;
  int n_chk = 0, n_bad = 0;
  bit done = 0;

  always #(TCLK/2) clk = ~clk;

  bkup_seq #(.W(W), .VALID(300), .QLEN(16)) uut (
    .clk(clk), .rst_n(rst_n), .we(we), .wd_arm(wd_arm), .wd_rev(wd_rev),
    .wd_acdis(wd_acdis), .mask(mask), .keep_sw(keep_sw), .thr_sel(thr_sel),
    .flag_clr(flag_clr), .vbus(vbus), .vlim(vlim), .ovp_trip(ovp_trip),
    .sw_found(sw_found), .arm(arm), .rev_en(rev_en), .acdrv_off(acdrv_off),
    .stat(stat), .irq(irq), .flag(flag));

  task automatic chk(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic cyc();
    @(posedge clk); @(negedge clk);
  endtask

  task automatic wr(input logic a, input logic r, input logic d);
    we = 1; wd_arm = a; wd_rev = r; wd_acdis = d;
    cyc();
    we = 0;
  endtask

  task automatic edges_to_fwd(output int n);
    n = 0;
    for (int i = 1; i <= 40; i++) begin
      cyc();
      if (stat == 4'b0001) begin n = i; break; end
      if (stat != 4'b0000) begin n = -i; break; end
    end
  endtask

  task automatic t_reset();
    repeat (3) cyc();
    rst_n = 1;
    cyc();
    chk("R12 arm", arm, 0); chk("R12 rev_en", rev_en, 0);
    chk("R12 acdrv_off", acdrv_off, 0); chk("R12 irq", irq, 0);
    chk("R12 flag", flag, 0); chk("R10 idle stat", stat, 0);
  endtask

  task automatic t_attach();
    int n;
    vbus = 12'd1000;
    edges_to_fwd(n);
    chk("R9 attach qualification edges", n, 17);
  endtask

  task automatic t_arm_rev();
    wr(1, 1, 0);
    chk("R1 arm accepted with bus valid", arm, 1);
    chk("R2 rev set ignored with bus valid", rev_en, 0);
    chk("R10 forward stat", stat, 1);
  endtask

  task automatic t_thresholds();
    int p [4] = '{4, 6, 7, 8};
    for (int s = 0; s < 4; s++) begin
      thr_sel = 2'(s);
      vbus = 12'(100 * p[s]);
      cyc();
      chk("R3 at threshold no trigger", stat, 1);
      vbus = 12'(100 * p[s] - 1);
      cyc();
      chk("R3 below threshold trigger", stat, 4'b1100);
      chk("R4 rev_en forced", rev_en, 1);
      chk("R4 acdrv_off set", acdrv_off, 1);
      chk("R5 irq on entry", irq, 1);
      chk("R5 flag set", flag, 1);
      cyc();
      chk("R5 irq single cycle", irq, 0);
      vbus = 12'd1000; keep_sw = 1;
      wr(1, 0, 0);
      chk("R8 fast exit stat", stat, 1);
      chk("R8 acdrv_off cleared", acdrv_off, 0);
      chk("R8 rev_en cleared", rev_en, 0);
      flag_clr = 1; cyc(); flag_clr = 0;
      chk("R11 flag cleared", flag, 0);
    end
  endtask

  task automatic t_mask_slow_exit();
    int n;
    mask = 1; thr_sel = 2'd3; vbus = 12'd700;
    cyc();
    chk("R5 masked entry stat", stat, 4'b1100);
    chk("R5 masked irq", irq, 0);
    chk("R5 masked flag", flag, 0);
    vbus = 12'd1000; keep_sw = 0;
    we = 1; wd_arm = 1; wd_rev = 0; wd_acdis = 0;
    @(posedge clk); @(negedge clk); we = 0;
    chk("R9 qualification stat", stat, 0);
    n = 1;
    begin
      int m;
      edges_to_fwd(m);
      n = (m > 0) ? m + 1 : m;
    end
    chk("R9 exit qualification edges", n, 17);
    chk("R9 acdrv_off cleared", acdrv_off, 0);
    mask = 0;
  endtask

  task automatic t_ovp();
    wr(0, 0, 0);
    chk("R1 arm cleared by write", arm, 0);
    ovp_trip = 1;
    cyc();
    chk("R6 ovp backup stat", stat, 4'b1100);
    chk("R6 ovp acdrv_off", acdrv_off, 1);
    ovp_trip = 0; keep_sw = 1;
    wr(0, 0, 0);
    chk("R8 fast exit after ovp", stat, 1);
    flag_clr = 1; cyc(); flag_clr = 0;
  endtask

  task automatic t_set_wins();
    wr(1, 0, 0);
    thr_sel = 2'd3; vbus = 12'd750; flag_clr = 1;
    cyc();
    flag_clr = 0;
    chk("R11 set wins over clear", flag, 1);
    vbus = 12'd1000; keep_sw = 1;
    wr(1, 0, 0);
    flag_clr = 1; cyc(); flag_clr = 0;
    chk("R11 flag cleared after", flag, 0);
  endtask

  task automatic t_bus_low();
    vbus = 12'd100;
    cyc();
    chk("R1 arm cleared on bus low", arm, 0);
    chk("R3 trigger on bus collapse", stat, 4'b1100);
    keep_sw = 0;
    wr(0, 0, 0);
    cyc();
    chk("R10 idle after drop", stat, 0);
    wr(1, 1, 0);
    chk("R1 arm write refused bus low", arm, 0);
    chk("R2 rev set accepted bus low", rev_en, 1);
    wr(0, 0, 0);
    chk("R2 rev clear", rev_en, 0);
  endtask

  task automatic t_no_switch();
    int n;
    sw_found = 0; vbus = 12'd1000;
    edges_to_fwd(n);
    chk("R9 attach qualification edges again", n, 17);
    wr(1, 0, 0);
    chk("R7 arm held low", arm, 0);
    thr_sel = 2'd3; vbus = 12'd750;
    cyc(); cyc();
    chk("R7 no backup without arm", stat, 1);
    vbus = 12'd100;
    cyc();
    chk("R10 drop to idle", stat, 0);
  endtask

  initial begin
    @(negedge clk);
    t_reset();
    t_attach();
    t_arm_rev();
    t_thresholds();
    t_mask_slow_exit();
    t_ovp();
    t_set_wins();
    t_bus_low();
    t_no_switch();
    if (!done) begin
      done = 1;
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1;
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end
endmodule